// File: doc/BRIEF.md
# Host Bus Register Decode Interface

This block is the slave side of a byte-wide host controller bus inside an acquisition module. The host presents an address and a set of active-low strobes (write, read, port select, slot select, personality). The block decodes the low four address bits under those strobes. From that decode it pulses load enables for eight control registers, gates status sources onto a shared 8-bit data bus, issues a load strobe to the threshold DAC, and selects one of two configuration ROMs. The ROM bank is chosen by a separate map input, not by address.

Three of the control registers are held locally and their fields are driven straight to the acquisition logic:
- the clock-source select register;
- the word-recogniser register;
- the trigger-control register, including its initialisation bit.

All three can be read back over the same bus. The data bus is modelled as a value plus an output enable. When the enable is low the bus is high-impedance.

Top module: `hbd_host_if`

## Requirements
- R1: Only address bits [3:0] take part in any decode; higher bus address bits are ignored (address 0x13 acts as 0x3, 0x31 as 0x1).
- R2: `data_oe_o` is high only while `rd_ni` and `port_ni` are both low and the address is mapped for reads; otherwise the bus is not driven and `rd_en_o` is all zero.
- R3: The read map is as follows. Addresses 0–7 drive `rd_src_i` slice n (bits [8n+7:8n]) onto `data_o` and raise `rd_en_o[n]` only; address 1 is the probe status source. Addresses 8, 9 and 10 read back the clock-select, word-recogniser and trigger-control registers. Addresses 11–15 are unmapped.
- R4: A register write needs `wr_ni`, `port_ni` and `slot_ni` all low. After the first rising clock edge at which all three are seen low, `ld_en_o[a]` (address a in 0–7) is high for exactly one cycle, even if the strobes stay low. The matching stored register takes `data_i` at that same edge.
- R5: A write attempt with `slot_ni` high or `port_ni` high produces no load enable, no DAC strobe and no change to any stored register.
- R6: When `rd_ni`, `pers_ni` and `slot_ni` are low and `port_ni` is high, `rom_cs_o` is 2'b01 with `map_i` low and 2'b10 with `map_i` high. `data_oe_o` stays low during such a read. Otherwise `rom_cs_o` is 2'b00.
- R7: A port read takes priority. With `port_ni` low, `rom_cs_o` is 2'b00, so at most one source drives the bus.
- R8: A write to address 8 pulses `thr_ld_o` for exactly one cycle, with the same timing as R4, and raises no `ld_en_o` bit.
- R9: The clock-select register is loaded at address 0. `clk_src_o` = {d5,d4,d2,d1,d0} and `login_set_o` = d7.
- R10: The trigger-control register is loaded at address 3. `arm_mode_o` = d[5:4] (slow-card or self arming). `trig_init_o` and `login_clr_o` both follow d7.
- R11: The word-recogniser register is loaded at address 2. `dc_mask_o` = d[3:0] (per-channel don't-care) and `match_o` = d[7:4].
- R12: While `rst_ni` is low, every stored register, `ld_en_o` and `thr_ld_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Host address bus |
| data_i | input | 8 | Host write data |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| port_ni | input | 1 | Port select, active low |
| slot_ni | input | 1 | Slot select, active low |
| pers_ni | input | 1 | Personality (ROM space) select, active low |
| map_i | input | 1 | ROM bank choice |
| rd_src_i | input | 64 | Eight 8-bit status sources, source n at [8n+7:8n] |
| data_o | output | 8 | Read data toward the host bus |
| data_oe_o | output | 1 | Bus drive enable; low means high-impedance |
| rd_en_o | output | 8 | One-hot read enable of the selected status source |
| rom_cs_o | output | 2 | ROM chip selects |
| wbuf_en_o | output | 1 | Write data buffer enable |
| ld_en_o | output | 8 | One-cycle load enables of the control registers |
| thr_ld_o | output | 1 | One-cycle threshold DAC load strobe |
| clk_src_o | output | 5 | Clock source select field |
| login_set_o | output | 1 | Login register preset |
| dc_mask_o | output | 4 | Word-recogniser don't-care mask |
| match_o | output | 4 | Word-recogniser match value |
| arm_mode_o | output | 2 | Arming source select |
| trig_init_o | output | 1 | Word recogniser / trigger delay initialise |
| login_clr_o | output | 1 | Login register clear |

## Verification
The read path, ROM selects and write buffer enable are combinational. The bench drives them at the falling edge and samples them two nanoseconds later, in the same cycle. Load enables, the DAC strobe and the stored register fields appear just after the first rising edge that sees the write strobes. The bench samples one nanosecond after that edge, then samples again after the following edge with the strobes still held, to confirm the pulse lasted a single cycle. Blocked writes are confirmed by reading the stored registers back over the bus before the next write.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int unsigned DEC_AW = 4;
  localparam int unsigned N_CTL  = 8;
  localparam int unsigned N_RB   = 3;

  // write map
  localparam logic [DEC_AW-1:0] WA_CLK_SEL = 4'd0;
  localparam logic [DEC_AW-1:0] WA_WREC    = 4'd2;
  localparam logic [DEC_AW-1:0] WA_TRIG    = 4'd3;
  localparam logic [DEC_AW-1:0] WA_THR     = 4'd8;

  // readback map, index order of rb_sel
  localparam logic [DEC_AW-1:0] RA_RB_BASE = 4'd8;

  typedef enum logic [1:0] {
    RB_CLK  = 2'd0,
    RB_WREC = 2'd1,
    RB_TRIG = 2'd2
  } rb_idx_e;
endpackage

// File: rtl/hbd_addr_dec.sv
module hbd_addr_dec
  import hbd_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic [DEC_AW-1:0] addr_i,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              port_ni,
  input  logic              slot_ni,
  input  logic              pers_ni,
  input  logic              map_i,
  output logic [N_SRC-1:0]  src_sel_o,
  output logic [N_RB-1:0]   rb_sel_o,
  output logic              wr_act_o,
  output logic [N_CTL-1:0]  wr_sel_o,
  output logic              thr_sel_o,
  output logic [1:0]        rom_cs_o,
  output logic              wbuf_en_o
);
  logic port_rd, rom_rd;

  assign port_rd   = !rd_ni && !port_ni;
  assign wbuf_en_o = !wr_ni && !port_ni && !slot_ni;
  assign wr_act_o  = wbuf_en_o;
  // port read wins over ROM space
  assign rom_rd    = !rd_ni && !pers_ni && !slot_ni && port_ni;
  assign rom_cs_o  = rom_rd ? (map_i ? 2'b10 : 2'b01) : 2'b00;
  assign thr_sel_o = (addr_i == WA_THR);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign src_sel_o[i] = port_rd && (addr_i == DEC_AW'(i));
  end

  for (genvar i = 0; i < N_RB; i++) begin : g_rb
    assign rb_sel_o[i] = port_rd && (addr_i == RA_RB_BASE + DEC_AW'(i));
  end

  for (genvar i = 0; i < N_CTL; i++) begin : g_wr
    assign wr_sel_o[i] = (addr_i == DEC_AW'(i));
  end
endmodule

// File: rtl/hbd_rd_mux.sv
module hbd_rd_mux
  import hbd_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned DW    = 8
) (
  input  logic [N_SRC-1:0]    src_sel_i,
  input  logic [N_RB-1:0]     rb_sel_i,
  input  logic [N_SRC*DW-1:0] src_i,
  input  logic [N_RB*DW-1:0]  rb_i,
  output logic [DW-1:0]       data_o,
  output logic                oe_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (src_sel_i[i]) data_o = data_o | src_i[i*DW +: DW];
    for (int i = 0; i < N_RB; i++)
      if (rb_sel_i[i]) data_o = data_o | rb_i[i*DW +: DW];
  end

  assign oe_o = |{src_sel_i, rb_sel_i};
endmodule

// File: rtl/hbd_ctl_regs.sv
module hbd_ctl_regs
  import hbd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_act_i,
  input  logic [N_CTL-1:0] wr_sel_i,
  input  logic             thr_sel_i,
  input  logic [DW-1:0]    data_i,
  output logic [N_CTL-1:0] ld_en_o,
  output logic             thr_ld_o,
  output logic [DW-1:0]    clk_sel_o,
  output logic [DW-1:0]    wrec_o,
  output logic [DW-1:0]    trig_o
);
  logic wr_act_q, wr_go;

  // one load per strobe assertion
  assign wr_go = wr_act_i && !wr_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      ld_en_o   <= '0;
      thr_ld_o  <= 1'b0;
      clk_sel_o <= '0;
      wrec_o    <= '0;
      trig_o    <= '0;
    end else begin
      wr_act_q <= wr_act_i;
      ld_en_o  <= wr_go ? wr_sel_i : '0;
      thr_ld_o <= wr_go && thr_sel_i;
      if (wr_go && wr_sel_i[WA_CLK_SEL]) clk_sel_o <= data_i;
      if (wr_go && wr_sel_i[WA_WREC])    wrec_o    <= data_i;
      if (wr_go && wr_sel_i[WA_TRIG])    trig_o    <= data_i;
    end
  end
endmodule

// File: rtl/hbd_host_if.sv
module hbd_host_if
  import hbd_pkg::*;
#(
  parameter int unsigned BUS_AW = 8,
  parameter int unsigned DW     = 8,
  parameter int unsigned N_SRC  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BUS_AW-1:0]   addr_i,
  input  logic [DW-1:0]       data_i,
  input  logic                wr_ni,
  input  logic                rd_ni,
  input  logic                port_ni,
  input  logic                slot_ni,
  input  logic                pers_ni,
  input  logic                map_i,
  input  logic [N_SRC*DW-1:0] rd_src_i,
  output logic [DW-1:0]       data_o,
  output logic                data_oe_o,
  output logic [N_SRC-1:0]    rd_en_o,
  output logic [1:0]          rom_cs_o,
  output logic                wbuf_en_o,
  output logic [N_CTL-1:0]    ld_en_o,
  output logic                thr_ld_o,
  output logic [4:0]          clk_src_o,
  output logic                login_set_o,
  output logic [3:0]          dc_mask_o,
  output logic [3:0]          match_o,
  output logic [1:0]          arm_mode_o,
  output logic                trig_init_o,
  output logic                login_clr_o
);
  logic [N_SRC-1:0]   src_sel;
  logic [N_RB-1:0]    rb_sel;
  logic               wr_act, thr_sel;
  logic [N_CTL-1:0]   wr_sel;
  logic [DW-1:0]      clk_sel_q, wrec_q, trig_q;
  logic [N_RB*DW-1:0] rb_bus;

  hbd_addr_dec #(.N_SRC(N_SRC)) u_dec (
    .addr_i    (addr_i[DEC_AW-1:0]),
    .wr_ni     (wr_ni),
    .rd_ni     (rd_ni),
    .port_ni   (port_ni),
    .slot_ni   (slot_ni),
    .pers_ni   (pers_ni),
    .map_i     (map_i),
    .src_sel_o (src_sel),
    .rb_sel_o  (rb_sel),
    .wr_act_o  (wr_act),
    .wr_sel_o  (wr_sel),
    .thr_sel_o (thr_sel),
    .rom_cs_o  (rom_cs_o),
    .wbuf_en_o (wbuf_en_o)
  );

  hbd_ctl_regs #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_act_i  (wr_act),
    .wr_sel_i  (wr_sel),
    .thr_sel_i (thr_sel),
    .data_i    (data_i),
    .ld_en_o   (ld_en_o),
    .thr_ld_o  (thr_ld_o),
    .clk_sel_o (clk_sel_q),
    .wrec_o    (wrec_q),
    .trig_o    (trig_q)
  );

  assign rb_bus[RB_CLK*DW  +: DW] = clk_sel_q;
  assign rb_bus[RB_WREC*DW +: DW] = wrec_q;
  assign rb_bus[RB_TRIG*DW +: DW] = trig_q;

  hbd_rd_mux #(.N_SRC(N_SRC), .DW(DW)) u_mux (
    .src_sel_i (src_sel),
    .rb_sel_i  (rb_sel),
    .src_i     (rd_src_i),
    .rb_i      (rb_bus),
    .data_o    (data_o),
    .oe_o      (data_oe_o)
  );

  assign rd_en_o     = src_sel;
  assign clk_src_o   = {clk_sel_q[5], clk_sel_q[4], clk_sel_q[2:0]};
  assign login_set_o = clk_sel_q[7];
  assign dc_mask_o   = wrec_q[3:0];
  assign match_o     = wrec_q[7:4];
  assign arm_mode_o  = trig_q[5:4];
  assign trig_init_o = trig_q[7];
  assign login_clr_o = trig_q[7];
endmodule

// File: rtl/hbd_host_if_chk.sv
module hbd_host_if_chk #(
  parameter int unsigned N_CTL = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_ni,
  input logic             rd_ni,
  input logic             port_ni,
  input logic             slot_ni,
  input logic             pers_ni,
  input logic             data_oe_o,
  input logic [1:0]       rom_cs_o,
  input logic [N_CTL-1:0] ld_en_o,
  input logic             thr_ld_o
);
  assert_drive_needs_port_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!rd_ni && !port_ni));

  assert_rom_strobes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o != 2'b00) |-> (!rd_ni && !pers_ni && !slot_ni && $onehot0(rom_cs_o)));

  assert_single_driver_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((rom_cs_o != 2'b00) && data_oe_o));

  assert_ld_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_en_o));

  assert_ld_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_o != '0) |=> (ld_en_o == '0));

  assert_ld_qualified_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ld_en_o != '0) || thr_ld_o) |-> $past(!wr_ni && !port_ni && !slot_ni));

  assert_thr_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_ld_o |=> !thr_ld_o);

  assert_thr_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_ld_o |-> (ld_en_o == '0));
endmodule

bind hbd_host_if hbd_host_if_chk #(.N_CTL(hbd_pkg::N_CTL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_ni     (wr_ni),
  .rd_ni     (rd_ni),
  .port_ni   (port_ni),
  .slot_ni   (slot_ni),
  .pers_ni   (pers_ni),
  .data_oe_o (data_oe_o),
  .rom_cs_o  (rom_cs_o),
  .ld_en_o   (ld_en_o),
  .thr_ld_o  (thr_ld_o)
);

// File: tb/sim_hbd_host_if.sv
`timescale 1ns/1ps
module sim_hbd_host_if;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        wr_ni = 1'b1, rd_ni = 1'b1, port_ni = 1'b1, slot_ni = 1'b1, pers_ni = 1'b1;
  logic        map_i = 1'b0;
  logic [63:0] rd_src_i;
  logic [7:0]  data_o;
  logic        data_oe_o;
  logic [7:0]  rd_en_o;
  logic [1:0]  rom_cs_o;
  logic        wbuf_en_o;
  logic [7:0]  ld_en_o;
  logic        thr_ld_o;
  logic [4:0]  clk_src_o;
  logic        login_set_o;
  logic [3:0]  dc_mask_o, match_o;
  logic [1:0]  arm_mode_o;
  logic        trig_init_o, login_clr_o;

  int n_chk = 0, n_err = 0;
  logic [7:0] ld1, ld2;
  logic       th1, th2;

  always #10 clk_i = ~clk_i;

  hbd_host_if u0 (.*);

  initial begin
    for (int i = 0; i < 8; i++) rd_src_i[i*8 +: 8] = 8'hA0 + 8'(i);
    rd_src_i[15:8] = 8'h5C; // probe status
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                          input logic port_n, input logic slot_n);
    @(negedge clk_i);
    addr_i = a; data_i = d; wr_ni = 1'b0; port_ni = port_n; slot_ni = slot_n;
    @(posedge clk_i); #1;
    ld1 = ld_en_o; th1 = thr_ld_o;
    @(posedge clk_i); #1;
    ld2 = ld_en_o; th2 = thr_ld_o;
    @(negedge clk_i);
    wr_ni = 1'b1; port_ni = 1'b1; slot_ni = 1'b1;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d,
                         output logic oe, output logic [7:0] en);
    @(negedge clk_i);
    addr_i = a; rd_ni = 1'b0; port_ni = 1'b0;
    #2;
    d = data_o; oe = data_oe_o; en = rd_en_o;
    @(negedge clk_i);
    rd_ni = 1'b1; port_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d, en; logic oe;
    #5;
    chk("R12 ld_en in reset", ld_en_o, 0);
    chk("R12 thr_ld in reset", thr_ld_o, 0);
    chk("R12 fields in reset", {clk_src_o, login_set_o, dc_mask_o, match_o,
                                arm_mode_o, trig_init_o, login_clr_o}, 0);
    rst_ni = 1'b1;
    do_read(8'h08, d, oe, en); chk("R12 clk sel readback", d, 0);
    do_read(8'h0A, d, oe, en); chk("R12 trig readback", d, 0);
  endtask

  task automatic t_reads();
    logic [7:0] d, en; logic oe;
    do_read(8'h01, d, oe, en);
    chk("R3 probe status data", d, 8'h5C); chk("R3 probe status en", en, 8'h02);
    chk("R2 oe on read", oe, 1);
    do_read(8'h05, d, oe, en);
    chk("R3 src5 data", d, 8'hA5); chk("R3 src5 en", en, 8'h20);
    do_read(8'h31, d, oe, en);
    chk("R1 alias read of addr 1", d, 8'h5C);
    do_read(8'h0C, d, oe, en);
    chk("R3 unmapped oe", oe, 0); chk("R3 unmapped en", en, 0);
    @(negedge clk_i);
    addr_i = 8'h01; rd_ni = 1'b0; port_ni = 1'b1; #2;
    chk("R2 no port no drive", data_oe_o, 0);
    chk("R2 no port no rd_en", rd_en_o, 0);
    rd_ni = 1'b1;
  endtask

  task automatic t_writes();
    logic [7:0] d, en; logic oe;
    do_write(8'h00, 8'h95, 1'b0, 1'b0);
    chk("R4 clk sel ld pulse", ld1, 8'h01); chk("R4 ld drops while held", ld2, 0);
    chk("R9 clk_src", clk_src_o, 5'b01101); chk("R9 login_set", login_set_o, 1);
    do_read(8'h08, d, oe, en); chk("R9 readback", d, 8'h95);
    do_write(8'h02, 8'h6C, 1'b0, 1'b0);
    chk("R4 wrec ld", ld1, 8'h04);
    chk("R11 mask", dc_mask_o, 4'hC); chk("R11 match", match_o, 4'h6);
    do_write(8'h03, 8'hA0, 1'b0, 1'b0);
    chk("R4 trig ld", ld1, 8'h08);
    chk("R10 arm", arm_mode_o, 2'b10);
    chk("R10 init/clr", {trig_init_o, login_clr_o}, 2'b11);
    do_write(8'hF3, 8'h10, 1'b0, 1'b0);
    chk("R1 alias write ld", ld1, 8'h08);
    chk("R1 alias write arm", arm_mode_o, 2'b01);
    chk("R10 init cleared", {trig_init_o, login_clr_o}, 2'b00);
    do_write(8'h05, 8'h33, 1'b0, 1'b0);
    chk("R4 addr5 ld", ld1, 8'h20); chk("R8 no thr on addr5", th1, 0);
  endtask

  task automatic t_blocked();
    logic [7:0] d, en; logic oe;
    do_write(8'h02, 8'hFF, 1'b0, 1'b1);
    chk("R5 no slot no ld", ld1, 0);
    do_read(8'h09, d, oe, en); chk("R5 no slot keeps wrec", d, 8'h6C);
    do_write(8'h08, 8'hFF, 1'b1, 1'b0);
    chk("R5 no port no ld", ld1, 0); chk("R5 no port no thr", th1, 0);
    do_write(8'h00, 8'h00, 1'b1, 1'b0);
    do_read(8'h08, d, oe, en); chk("R5 no port keeps clk sel", d, 8'h95);
  endtask

  task automatic t_thr();
    do_write(8'h08, 8'h7E, 1'b0, 1'b0);
    chk("R8 thr pulse", th1, 1); chk("R8 thr drops", th2, 0);
    chk("R8 no ld on thr", ld1, 0);
  endtask

  task automatic t_rom();
    @(negedge clk_i);
    addr_i = 8'h01; rd_ni = 1'b0; pers_ni = 1'b0; slot_ni = 1'b0; map_i = 1'b0; #2;
    chk("R6 rom0 select", rom_cs_o, 2'b01); chk("R6 no bus drive", data_oe_o, 0);
    map_i = 1'b1; #2;
    chk("R6 rom1 select", rom_cs_o, 2'b10);
    port_ni = 1'b0; #2;
    chk("R7 port wins rom", rom_cs_o, 2'b00); chk("R7 port read drives", data_oe_o, 1);
    port_ni = 1'b1; pers_ni = 1'b1; #2;
    chk("R6 no personality", rom_cs_o, 2'b00);
    rd_ni = 1'b1; slot_ni = 1'b1; map_i = 1'b0;
  endtask

  task automatic t_wbuf();
    @(negedge clk_i);
    wr_ni = 1'b0; port_ni = 1'b0; slot_ni = 1'b1; addr_i = 8'h0F; #2;
    chk("R4 wbuf needs slot", wbuf_en_o, 0);
    slot_ni = 1'b0; #2;
    chk("R4 wbuf on", wbuf_en_o, 1);
    @(negedge clk_i);
    wr_ni = 1'b1; port_ni = 1'b1; slot_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_reads();
    t_writes();
    t_blocked();
    t_thr();
    t_rom();
    t_wbuf();
    repeat (3) @(posedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule